// File: doc/BRIEF.md
# Resume Flag Controller

This block keeps the resume flag of a processor core. While the flag is set, a matching instruction breakpoint is masked, so a handler that returns to the faulting instruction does not take the same breakpoint again. The flag is cleared each time an instruction begins, once the breakpoint match for that instruction has been taken. It is reloaded from a saved image only when the return is an interrupt return or a task switch.

The second job is to compute the resume-flag bit that goes into the flags image when an event handler is entered. The core presents an event descriptor: the event class, whether the event is an instruction-breakpoint debug fault, whether it is a software interrupt, and whether it hit a repeated string instruction before its last iteration. The block answers with the bit to save. Writing the image to the stack is the job of other logic.

Top module: `rsm_flag_ctl`

## Requirements
- R1: After reset, `rf_live`, `save_vld` and `save_rf` are all 0.
- R2: `insn_start` high at a clock edge makes `rf_live` 0 after that edge, unless a restoring return is presented at the same edge.
- R3: An event of class fault (`evt_class` = 2'b00) with `evt_ibp` low saves 1.
- R4: An event of class trap (2'b01) or interrupt (2'b10) with `evt_rep_mid` high saves 1.
- R5: An interrupt (2'b10) with `evt_swint` high and `evt_rep_mid` low saves 0.
- R6: Every other event saves `rf_live` as it stood before the edge, even if `insn_start` clears it at that edge. This covers a fault with `evt_ibp` high, a trap or interrupt with neither `evt_rep_mid` nor `evt_swint` set, and the reserved class 2'b11.
- R7: With the default registered output, `save_vld` is high for exactly the cycle after each cycle in which `evt_valid` is high, and `save_rf` carries the saved bit during that cycle. `save_rf` holds its value while no event is presented.
- R8: A return with `ret_kind` 2'b00 (interrupt return) or 2'b01 (task switch) loads `ret_rf_img` into `rf_live` at the edge. This load takes priority over a same-edge `insn_start`.
- R9: A return with `ret_kind` 2'b10 (pop-flags write) or 2'b11 (reserved) leaves `rf_live` unchanged.
- R10: `bp_fire` equals `bp_match` while `rf_live` is 0, and is all zeros while `rf_live` is 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_start | input | 1 | Instruction begins; the breakpoint check has already been made |
| bp_match | input | NUM_BP | Raw instruction-breakpoint matches, one bit per slot |
| evt_valid | input | 1 | Handler entry this cycle |
| evt_class | input | 2 | 00 fault, 01 trap, 10 interrupt, 11 reserved |
| evt_ibp | input | 1 | Event is an instruction-breakpoint debug fault |
| evt_swint | input | 1 | Event is a software interrupt |
| evt_rep_mid | input | 1 | Event falls on a non-final iteration of a repeated string instruction |
| ret_valid | input | 1 | Flags return event this cycle |
| ret_kind | input | 2 | 00 interrupt return, 01 task switch, 10 pop-flags write, 11 reserved |
| ret_rf_img | input | 1 | Resume bit of the image being returned to |
| rf_live | output | 1 | Live resume flag |
| bp_fire | output | NUM_BP | Breakpoint matches after the resume mask |
| save_vld | output | 1 | Saved value is valid |
| save_rf | output | 1 | Resume bit to store in the handler's flags image |

## Verification
Two functions can act in the same cycle: the clear at instruction start, and either an event that samples the flag or a return that reloads it. The bench sets the flag through an interrupt return. It then asserts `insn_start` together with a trap event and expects the saved bit to be the pre-clear 1 while the flag drops. It also asserts `insn_start` together with an interrupt return carrying a 1 and expects the flag to end up as 1.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
   typedef enum logic [1:0] {
      EVC_FAULT = 2'b00,
      EVC_TRAP  = 2'b01,
      EVC_INTR  = 2'b10,
      EVC_RSVD  = 2'b11
   } evt_class_e;

   typedef enum logic [1:0] {
      RET_IRET = 2'b00,
      RET_TASK = 2'b01,
      RET_POPF = 2'b10,
      RET_RSVD = 2'b11
   } ret_kind_e;

   function automatic logic rsm_restores(input logic [1:0] kind);
      return (kind == RET_IRET) || (kind == RET_TASK);
   endfunction
endpackage

// File: rtl/rsm_save_sel.sv
module rsm_save_sel
   import rsm_pkg::*;
(
   input  logic [1:0] cls,
   input  logic       ibp,
   input  logic       swint,
   input  logic       rep_mid,
   input  logic       live,
   output logic       val
);
   logic is_fault, is_trap, is_intr;

   always_comb begin
      is_fault = (cls == EVC_FAULT);
      is_trap  = (cls == EVC_TRAP);
      is_intr  = (cls == EVC_INTR);
      if (is_fault && !ibp)
         val = 1'b1;
      else if ((is_trap || is_intr) && rep_mid)
         val = 1'b1;
      else if (is_intr && swint)
         val = 1'b0;
      else
         val = live;
   end
endmodule

// File: rtl/rsm_live_reg.sv
module rsm_live_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ld,
   input  logic ld_val,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= 1'b0;
      else if (ld)  q <= ld_val;
      else if (clr) q <= 1'b0;
   end

   a_r8_restore_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (q == $past(ld_val)));
   a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !ld) |=> !q);
   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !ld) |=> $stable(q));
endmodule

// File: rtl/rsm_bp_gate.sv
module rsm_bp_gate #(
   parameter int NUM_BP = 4
) (
   input  logic              suppress,
   input  logic [NUM_BP-1:0] match,
   output logic [NUM_BP-1:0] fire
);
   for (genvar g = 0; g < NUM_BP; g++) begin : g_slot
      assign fire[g] = match[g] & ~suppress;
   end
endmodule

// File: rtl/rsm_flag_ctl.sv
module rsm_flag_ctl
   import rsm_pkg::*;
#(
   parameter int NUM_BP   = 4,
   parameter bit SAVE_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_start,
   input  logic [NUM_BP-1:0] bp_match,
   input  logic              evt_valid,
   input  logic [1:0]        evt_class,
   input  logic              evt_ibp,
   input  logic              evt_swint,
   input  logic              evt_rep_mid,
   input  logic              ret_valid,
   input  logic [1:0]        ret_kind,
   input  logic              ret_rf_img,
   output logic              rf_live,
   output logic [NUM_BP-1:0] bp_fire,
   output logic              save_vld,
   output logic              save_rf
);
   localparam int MAX_BP = 16;

   if (NUM_BP < 1 || NUM_BP > MAX_BP) begin : g_bad_bp
      $error("rsm_flag_ctl: NUM_BP out of range");
   end

   logic restore_ld;
   logic save_next;

   assign restore_ld = ret_valid && rsm_restores(ret_kind);

   rsm_live_reg i_live (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (insn_start),
      .ld     (restore_ld),
      .ld_val (ret_rf_img),
      .q      (rf_live)
   );

   rsm_save_sel i_sel (
      .cls     (evt_class),
      .ibp     (evt_ibp),
      .swint   (evt_swint),
      .rep_mid (evt_rep_mid),
      .live    (rf_live),
      .val     (save_next)
   );

   rsm_bp_gate #(.NUM_BP(NUM_BP)) i_gate (
      .suppress (rf_live),
      .match    (bp_match),
      .fire     (bp_fire)
   );

   if (SAVE_REG) begin : g_save_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            save_vld <= 1'b0;
            save_rf  <= 1'b0;
         end else begin
            save_vld <= evt_valid;
            if (evt_valid) save_rf <= save_next;
         end
      end

      a_r3_fault_saves_one: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_valid && evt_class == EVC_FAULT && !evt_ibp) |=> (save_vld && save_rf));
      a_r4_rep_mid_saves_one: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_valid && (evt_class == EVC_TRAP || evt_class == EVC_INTR) && evt_rep_mid)
         |=> save_rf);
      a_r5_swint_saves_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_valid && evt_class == EVC_INTR && evt_swint && !evt_rep_mid) |=> !save_rf);
      a_r6_ibp_saves_live: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_valid && evt_class == EVC_FAULT && evt_ibp) |=> (save_rf == $past(rf_live)));
      a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
         !evt_valid |=> (!save_vld && $stable(save_rf)));
   end else begin : g_save_comb
      assign save_vld = evt_valid;
      assign save_rf  = save_next;

      a_r3_fault_saves_one: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_valid && evt_class == EVC_FAULT && !evt_ibp) |-> save_rf);
   end

   a_r10_mask_while_set: assert property (@(posedge clk) disable iff (!rst_n)
      rf_live |-> (bp_fire == '0));
endmodule

// File: tb/test_rsm_flag_ctl.sv
module test_rsm_flag_ctl;
   localparam int NB = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          insn_start;
   logic [NB-1:0] bp_match;
   logic          evt_valid;
   logic [1:0]    evt_class;
   logic          evt_ibp, evt_swint, evt_rep_mid;
   logic          ret_valid;
   logic [1:0]    ret_kind;
   logic          ret_rf_img;
   logic          rf_live;
   logic [NB-1:0] bp_fire;
   logic          save_vld, save_rf;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   rsm_flag_ctl #(.NUM_BP(NB)) i_rsm_flag_ctl (
      .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .bp_match(bp_match),
      .evt_valid(evt_valid), .evt_class(evt_class), .evt_ibp(evt_ibp),
      .evt_swint(evt_swint), .evt_rep_mid(evt_rep_mid), .ret_valid(ret_valid),
      .ret_kind(ret_kind), .ret_rf_img(ret_rf_img), .rf_live(rf_live),
      .bp_fire(bp_fire), .save_vld(save_vld), .save_rf(save_rf)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic model_save(input logic [1:0] c, input logic ibp,
                                       input logic sw, input logic rep, input logic live);
      if (c == 2'b00 && !ibp) return 1'b1;
      if ((c == 2'b01 || c == 2'b10) && rep) return 1'b1;
      if (c == 2'b10 && sw) return 1'b0;
      return live;
   endfunction

   task automatic idle();
      insn_start = 0; bp_match = '0; evt_valid = 0; evt_class = 0;
      evt_ibp = 0; evt_swint = 0; evt_rep_mid = 0;
      ret_valid = 0; ret_kind = 0; ret_rf_img = 0;
   endtask

   task automatic set_live(input logic v);
      @(negedge clk);
      idle();
      ret_valid = 1; ret_kind = 2'b00; ret_rf_img = v;
      @(negedge clk);
      idle();
   endtask

   task automatic t_reset();
      rst_n = 0; idle();
      repeat (3) @(negedge clk);
      check("R1 rf_live", rf_live, 0);
      check("R1 save_vld", save_vld, 0);
      check("R1 save_rf", save_rf, 0);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic t_restore();
      set_live(1);
      check("R8 iret loads 1", rf_live, 1);
      @(negedge clk);
      ret_valid = 1; ret_kind = 2'b01; ret_rf_img = 0;
      @(negedge clk); idle();
      check("R8 task switch loads 0", rf_live, 0);
      set_live(0);
      @(negedge clk);
      ret_valid = 1; ret_kind = 2'b01; ret_rf_img = 1;
      @(negedge clk); idle();
      check("R8 task switch loads 1", rf_live, 1);
   endtask

   task automatic t_popf();
      set_live(1);
      ret_valid = 1; ret_kind = 2'b10; ret_rf_img = 0;
      @(negedge clk); idle();
      check("R9 popf keeps 1", rf_live, 1);
      ret_valid = 1; ret_kind = 2'b11; ret_rf_img = 0;
      @(negedge clk); idle();
      check("R9 reserved keeps 1", rf_live, 1);
      set_live(0);
      ret_valid = 1; ret_kind = 2'b10; ret_rf_img = 1;
      @(negedge clk); idle();
      check("R9 popf keeps 0", rf_live, 0);
   endtask

   task automatic t_clear();
      set_live(1);
      insn_start = 1;
      @(negedge clk); idle();
      check("R2 start clears", rf_live, 0);
      @(negedge clk);
      check("R2 stays clear", rf_live, 0);
   endtask

   task automatic t_bp_mask();
      set_live(0);
      bp_match = 4'b1011;
      #1 check("R10 pass through", bp_fire, 4'b1011);
      set_live(1);
      bp_match = 4'b1111;
      #1 check("R10 masked", bp_fire, 4'b0000);
      insn_start = 1;
      @(negedge clk);
      insn_start = 0;
      #1 check("R10 unmasked after start", bp_fire, 4'b1111);
      idle();
   endtask

   task automatic t_events();
      for (int lv = 0; lv < 2; lv++) begin
         for (int k = 0; k < 32; k++) begin
            logic [1:0] c;
            logic ib, sw, rp, exp_v;
            c = k[1:0]; ib = k[2]; sw = k[3]; rp = k[4];
            set_live(lv[0]);
            evt_valid = 1; evt_class = c; evt_ibp = ib; evt_swint = sw; evt_rep_mid = rp;
            exp_v = model_save(c, ib, sw, rp, lv[0]);
            @(negedge clk); idle();
            check("R7 save_vld pulse", save_vld, 1);
            if (c == 2'b00 && !ib)                       check("R3 fault saves", save_rf, exp_v);
            else if ((c == 2'b01 || c == 2'b10) && rp)   check("R4 rep mid saves", save_rf, exp_v);
            else if (c == 2'b10 && sw)                   check("R5 swint saves", save_rf, exp_v);
            else                                          check("R6 saves live", save_rf, exp_v);
            @(negedge clk);
            check("R7 save_vld drops", save_vld, 0);
            check("R7 save_rf holds", save_rf, exp_v);
         end
      end
   endtask

   task automatic t_same_cycle();
      set_live(1);
      insn_start = 1; evt_valid = 1; evt_class = 2'b01;
      @(negedge clk); idle();
      check("R6 pre-clear value saved", save_rf, 1);
      check("R2 cleared with event", rf_live, 0);
      insn_start = 1; ret_valid = 1; ret_kind = 2'b00; ret_rf_img = 1;
      @(negedge clk); idle();
      check("R8 restore beats clear", rf_live, 1);
      insn_start = 1; ret_valid = 1; ret_kind = 2'b10; ret_rf_img = 1;
      @(negedge clk); idle();
      check("R2 popf does not block clear", rf_live, 0);
   endtask

   initial begin
      for (int i = 0; i < 20000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_restore();
      t_popf();
      t_clear();
      t_bp_mask();
      t_events();
      t_same_cycle();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule